// File: doc/BRIEF.md
# Dual-Path Buffer Throttle Generator

A front-end readout board keeps two independent event buffers. One holds data for the first trigger level and the other holds data for the high-level trigger. This block keeps a running count of the entries in each buffer. The count is driven by the buffer's own push and pop strobes. When a buffer gets close to full, the block raises a throttle request for that buffer's trigger level. The request goes to the central timing and fast-control system, which ORs it with the requests from every other board.

Each path has its own pair of watermarks that can be changed at run time. The throttle turns on when the occupancy reaches the upper mark. It stays on until the occupancy has drained to the lower mark, so the request does not chatter around a single threshold. Configuration uses a small write port: four watermark slots and one clear slot. The clear slot resets the sticky flags that record a push dropped by a full buffer. The block does not store, format or zero-suppress any data.

Top module: `buffer_throttle_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, both levels read 0, both throttles and both overflow flags are 0, every upper watermark is `HIGH_INIT` (12) and every lower watermark is `LOW_INIT` (8).
- R2: A push alone raises a path's level by one and a pop alone lowers it by one. A push and a pop in the same cycle leave the level unchanged. The new level shows on the cycle after the strobe.
- R3: A push without a pop while the level equals `CAP` (16) is dropped: the level stays at `CAP` and the path's overflow flag reads 1 from the next cycle on.
- R4: A pop without a push while the level is 0 has no effect: the level stays 0.
- R5: A throttle output is a register. It is 1 on the cycle after any cycle in which the path's level is at or above its upper watermark.
- R6: Once on, a throttle stays on while the level is above the lower watermark. It turns off on the cycle after the level is both at or below the lower mark and below the upper mark.
- R7: A write with `cfg_we`=1 stores `cfg_wdata` into a watermark at the clock edge. Address 0 is the first-level upper mark, 1 the first-level lower mark, 2 the high-level upper mark and 3 the high-level lower mark. The new value governs the throttle from the next comparison on.
- R8: A lower watermark set above its path's upper watermark behaves as if it equalled the upper watermark.
- R9: A write to address 4 clears the first-level overflow flag when `cfg_wdata[0]` is 1 and the high-level flag when `cfg_wdata[1]` is 1. A flag whose bit is 0 is untouched. A drop and a clear in the same cycle leave the flag set.
- R10: Strobes, writes and drops on one path never change the other path's level, throttle or overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_push | input | 1 | First-level buffer write strobe |
| l1_pop | input | 1 | First-level buffer read strobe |
| hlt_push | input | 1 | High-level buffer write strobe |
| hlt_pop | input | 1 | High-level buffer read strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration slot (0..3 watermarks, 4 clear) |
| cfg_wdata | input | LW (5) | Configuration write data |
| l1_level | output | LW (5) | First-level buffer occupancy |
| hlt_level | output | LW (5) | High-level buffer occupancy |
| l1_ovf | output | 1 | Sticky first-level dropped-push flag |
| hlt_ovf | output | 1 | Sticky high-level dropped-push flag |
| l1_throttle | output | 1 | Registered first-level throttle request |
| hlt_throttle | output | 1 | Registered high-level throttle request |

## Verification
The assertions assume that the strobes and configuration inputs are synchronous to `clk` and settle between edges. They also assume that no watermark is written above `CAP`, and they give no meaning to configuration addresses 5 to 7. The stimulus changes every input one time unit after a rising edge. It only writes addresses 0 to 4, with watermark values at or below the capacity. To reach the drop and empty-pop cases, it drives the level counters past the real buffer's limits on purpose.

// File: rtl/buffer_throttle_pkg.sv
package buffer_throttle_pkg;

    localparam int NUM_PATHS = 2;

    typedef enum logic [2:0] {
        SLOT_L1_HIGH  = 3'd0,
        SLOT_L1_LOW   = 3'd1,
        SLOT_HLT_HIGH = 3'd2,
        SLOT_HLT_LOW  = 3'd3,
        SLOT_CLR_OVF  = 3'd4
    } cfg_slot_e;

    typedef struct packed {
        logic push;
        logic pop;
    } strobe_t;

    function automatic logic [2:0] high_slot(input int path);
        return 3'(2 * path);
    endfunction

    function automatic logic [2:0] low_slot(input int path);
        return 3'(2 * path + 1);
    endfunction

endpackage

// File: rtl/thr_level_counter.sv
module thr_level_counter
    import buffer_throttle_pkg::*;
#(
    parameter int CAP = 16,
    parameter int LW  = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  strobe_t       strb,
    input  logic          clr_ovf,
    output logic [LW-1:0] level,
    output logic          ovf
);
    localparam logic [LW-1:0] FULL = LW'(CAP);

    logic at_full, at_empty, grow, shrink, drop;

    always_comb begin
        at_full  = (level == FULL);
        at_empty = (level == '0);
        grow     = strb.push & ~strb.pop & ~at_full;
        shrink   = strb.pop & ~strb.push & ~at_empty;
        drop     = strb.push & ~strb.pop & at_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            ovf   <= 1'b0;
        end else begin
            if (grow)
                level <= level + 1'b1;
            else if (shrink)
                level <= level - 1'b1;
            ovf <= drop | (ovf & ~clr_ovf);
        end
    end

    p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
        level <= FULL);
    p_push_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (strb.push && !strb.pop && level < FULL) |=> level == $past(level) + 1'b1);
    p_both_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (strb.push && strb.pop) |=> $stable(level));
    p_pop_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (strb.pop && !strb.push && level == '0) |=> level == '0);
    p_drop_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (strb.push && !strb.pop && level == FULL) |=> (ovf && level == FULL));
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr_ovf) |=> ovf);

endmodule

// File: rtl/thr_cfg_bank.sv
module thr_cfg_bank
    import buffer_throttle_pkg::*;
#(
    parameter int LW        = 5,
    parameter int HIGH_INIT = 12,
    parameter int LOW_INIT  = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [2:0]                     addr,
    input  logic [LW-1:0]                  wdata,
    output logic [NUM_PATHS-1:0][LW-1:0]   high_mark,
    output logic [NUM_PATHS-1:0][LW-1:0]   low_mark,
    output logic [NUM_PATHS-1:0]           clr_ovf
);
    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        logic hit_high, hit_low;

        always_comb begin
            hit_high   = we && (addr == high_slot(p));
            hit_low    = we && (addr == low_slot(p));
            clr_ovf[p] = we && (addr == SLOT_CLR_OVF) && wdata[p];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                high_mark[p] <= LW'(HIGH_INIT);
                low_mark[p]  <= LW'(LOW_INIT);
            end else begin
                if (hit_high) high_mark[p] <= wdata;
                if (hit_low)  low_mark[p]  <= wdata;
            end
        end

        p_cfg_high_r7: assert property (@(posedge clk) disable iff (rst)
            (we && addr == high_slot(p)) |=> high_mark[p] == $past(wdata));
        p_cfg_low_r7: assert property (@(posedge clk) disable iff (rst)
            (we && addr == low_slot(p)) |=> low_mark[p] == $past(wdata));
        p_cfg_quiet_r7: assert property (@(posedge clk) disable iff (rst)
            !we |=> ($stable(high_mark[p]) && $stable(low_mark[p])));
    end

endmodule

// File: rtl/thr_hysteresis.sv
module thr_hysteresis #(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] high_mark,
    input  logic [LW-1:0] low_mark,
    output logic          throttle
);
    logic [LW-1:0] low_eff;
    logic          set_req, keep_req;

    always_comb begin
        low_eff  = (low_mark > high_mark) ? high_mark : low_mark;
        set_req  = (level >= high_mark);
        keep_req = throttle && (level > low_eff);
    end

    always_ff @(posedge clk) begin
        if (rst) throttle <= 1'b0;
        else     throttle <= set_req | keep_req;
    end

    p_assert_high_r5: assert property (@(posedge clk) disable iff (rst)
        (level >= high_mark) |=> throttle);
    p_stay_off_r6: assert property (@(posedge clk) disable iff (rst)
        (!throttle && level < high_mark) |=> !throttle);
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (throttle && level > low_mark && level > high_mark) |=> throttle);
    p_clamp_low_r8: assert property (@(posedge clk) disable iff (rst)
        (low_mark > high_mark && level < high_mark) |=> !throttle);

endmodule

// File: rtl/buffer_throttle_gen.sv
module buffer_throttle_gen
    import buffer_throttle_pkg::*;
#(
    parameter int  CAP       = 16,
    parameter int  HIGH_INIT = 12,
    parameter int  LOW_INIT  = 8,
    localparam int LW        = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          l1_push,
    input  logic          l1_pop,
    input  logic          hlt_push,
    input  logic          hlt_pop,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [LW-1:0] cfg_wdata,
    output logic [LW-1:0] l1_level,
    output logic [LW-1:0] hlt_level,
    output logic          l1_ovf,
    output logic          hlt_ovf,
    output logic          l1_throttle,
    output logic          hlt_throttle
);
    strobe_t [NUM_PATHS-1:0]         strb;
    logic    [NUM_PATHS-1:0][LW-1:0] high_mark, low_mark, level;
    logic    [NUM_PATHS-1:0]         clr_ovf, ovf, thr;

    assign strb[0] = '{push: l1_push,  pop: l1_pop};
    assign strb[1] = '{push: hlt_push, pop: hlt_pop};

    thr_cfg_bank #(.LW(LW), .HIGH_INIT(HIGH_INIT), .LOW_INIT(LOW_INIT)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .high_mark (high_mark),
        .low_mark  (low_mark),
        .clr_ovf   (clr_ovf)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        thr_level_counter #(.CAP(CAP), .LW(LW)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .strb    (strb[p]),
            .clr_ovf (clr_ovf[p]),
            .level   (level[p]),
            .ovf     (ovf[p])
        );

        thr_hysteresis #(.LW(LW)) u_hys (
            .clk       (clk),
            .rst       (rst),
            .level     (level[p]),
            .high_mark (high_mark[p]),
            .low_mark  (low_mark[p]),
            .throttle  (thr[p])
        );
    end

    assign l1_level     = level[0];
    assign hlt_level    = level[1];
    assign l1_ovf       = ovf[0];
    assign hlt_ovf      = ovf[1];
    assign l1_throttle  = thr[0];
    assign hlt_throttle = thr[1];

    p_quiet_hlt_r10: assert property (@(posedge clk) disable iff (rst)
        (!hlt_push && !hlt_pop) |=> $stable(hlt_level));
    p_quiet_l1_r10: assert property (@(posedge clk) disable iff (rst)
        (!l1_push && !l1_pop) |=> $stable(l1_level));
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (l1_level == '0 && hlt_level == '0 && !l1_throttle && !hlt_throttle));

endmodule

// File: tb/buffer_throttle_gen_tb.sv
module buffer_throttle_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CAP = 16;
    localparam int LW  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l1_push = 0, l1_pop = 0, hlt_push = 0, hlt_pop = 0, cfg_we = 0;
    logic [2:0] cfg_addr = '0;
    logic [LW-1:0] cfg_wdata = '0;
    logic [LW-1:0] l1_level, hlt_level;
    logic l1_ovf, hlt_ovf, l1_throttle, hlt_throttle;

    int total = 0;
    int fails = 0;
    int m_lvl[2], m_hi[2], m_lo[2];
    bit m_thr[2], m_ovf[2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    buffer_throttle_gen u_dut (
        .clk(clk), .rst(rst),
        .l1_push(l1_push), .l1_pop(l1_pop), .hlt_push(hlt_push), .hlt_pop(hlt_pop),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .l1_level(l1_level), .hlt_level(hlt_level), .l1_ovf(l1_ovf), .hlt_ovf(hlt_ovf),
        .l1_throttle(l1_throttle), .hlt_throttle(hlt_throttle)
    );

    // stimulus vectors: {l1_push, l1_pop, hlt_push, hlt_pop, repeat count}
    localparam logic [11:0] VEC [10] = '{
        {4'b1000, 8'd13}, {4'b1110, 8'd3},  {4'b0100, 8'd4},  {4'b0100, 8'd1},
        {4'b1010, 8'd3},  {4'b0010, 8'd8},  {4'b0011, 8'd2},  {4'b0001, 8'd14},
        {4'b0001, 8'd2},  {4'b0100, 8'd12}
    };

    task automatic check(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic compare_model(input string tag);
        check({tag, " l1 level (R2)"},    int'(l1_level),     m_lvl[0]);
        check({tag, " hlt level (R2)"},   int'(hlt_level),    m_lvl[1]);
        check({tag, " l1 ovf (R3)"},      int'(l1_ovf),       int'(m_ovf[0]));
        check({tag, " hlt ovf (R3)"},     int'(hlt_ovf),      int'(m_ovf[1]));
        check({tag, " l1 throttle (R5/R6)"},  int'(l1_throttle),  int'(m_thr[0]));
        check({tag, " hlt throttle (R5/R6)"}, int'(hlt_throttle), int'(m_thr[1]));
    endtask

    task automatic step(input logic a, input logic b, input logic c, input logic d,
                        input logic we, input int ad, input int wd, input string tag);
        bit pu[2], po[2];
        l1_push = a; l1_pop = b; hlt_push = c; hlt_pop = d;
        cfg_we = we; cfg_addr = 3'(ad); cfg_wdata = LW'(wd);
        pu[0] = a; po[0] = b; pu[1] = c; po[1] = d;
        @(posedge clk);
        for (int p = 0; p < 2; p++) begin
            int lo_eff;
            bit drop, clr;
            lo_eff = (m_lo[p] > m_hi[p]) ? m_hi[p] : m_lo[p];
            m_thr[p] = (m_lvl[p] >= m_hi[p]) || (m_thr[p] && m_lvl[p] > lo_eff);
            drop = pu[p] && !po[p] && m_lvl[p] == CAP;
            clr  = we && ad == 4 && wd[p];
            if (pu[p] && !po[p] && m_lvl[p] < CAP) m_lvl[p]++;
            else if (po[p] && !pu[p] && m_lvl[p] > 0) m_lvl[p]--;
            m_ovf[p] = drop || (m_ovf[p] && !clr);
            if (we && ad == 2 * p)     m_hi[p] = wd;
            if (we && ad == 2 * p + 1) m_lo[p] = wd;
        end
        #1;
        compare_model(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog (R1..all): actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            m_lvl[p] = 0; m_hi[p] = 12; m_lo[p] = 8; m_thr[p] = 0; m_ovf[p] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset l1 level", int'(l1_level), 0);
        check("R1 reset hlt level", int'(hlt_level), 0);
        check("R1 reset throttles", int'({l1_throttle, hlt_throttle}), 0);
        check("R1 reset ovf", int'({l1_ovf, hlt_ovf}), 0);
        rst = 1'b0;
        idle("R1 first cycle");

        // table walk: R2, R4, R5, R6 against default marks 12/8
        for (int v = 0; v < 10; v++) begin
            for (int r = 0; r < int'(VEC[v][7:0]); r++)
                step(VEC[v][11], VEC[v][10], VEC[v][9], VEC[v][8], 0, 0, 0, "vec");
        end
        check("R4 l1 empty after extra pops", int'(l1_level), 0);
        check("R4 hlt empty after extra pops", int'(hlt_level), 0);

        // R3 fill past capacity, R10 other path quiet
        for (int i = 0; i < CAP + 1; i++) step(1, 0, 0, 0, 0, 0, 0, "fill");
        check("R3 l1 level held at capacity", int'(l1_level), CAP);
        check("R3 l1 ovf set", int'(l1_ovf), 1);
        check("R10 hlt ovf untouched", int'(hlt_ovf), 0);
        check("R10 hlt level untouched", int'(hlt_level), 0);
        check("R10 hlt throttle untouched", int'(hlt_throttle), 0);
        check("R5 l1 throttle at full", int'(l1_throttle), 1);

        // R9 clear behaviour
        step(0, 0, 0, 0, 1, 4, 2, "clr hlt bit");
        check("R9 l1 ovf kept when its bit is 0", int'(l1_ovf), 1);
        step(0, 0, 0, 0, 1, 4, 1, "clr l1 bit");
        check("R9 l1 ovf cleared", int'(l1_ovf), 0);
        step(1, 0, 0, 0, 1, 4, 1, "drop+clr");
        check("R9 drop wins over clear", int'(l1_ovf), 1);
        step(1, 1, 0, 0, 1, 4, 3, "push+pop at full");
        check("R3 push+pop at full no drop", int'(l1_ovf), 0);
        check("R2 push+pop at full level", int'(l1_level), CAP);

        // drain, then R7 new marks on L1
        for (int i = 0; i < CAP; i++) step(0, 1, 0, 0, 0, 0, 0, "drain");
        step(0, 0, 0, 0, 1, 0, 4, "wr l1 high");
        step(0, 0, 0, 0, 1, 1, 2, "wr l1 low");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 0, "R7 push");
        idle("R7 settle");
        check("R7 l1 throttle at new high 4", int'(l1_throttle), 1);
        step(0, 1, 0, 0, 0, 0, 0, "R7 pop");
        idle("R7 hold");
        check("R7 l1 throttle held at 3 above low 2", int'(l1_throttle), 1);
        step(0, 1, 0, 0, 0, 0, 0, "R7 pop2");
        idle("R7 release");
        check("R7 l1 throttle released at low 2", int'(l1_throttle), 0);

        // R8 low above high on HLT
        step(0, 0, 0, 0, 1, 2, 5, "wr hlt high");
        step(0, 0, 0, 0, 1, 3, 10, "wr hlt low");
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 0, 0, "R8 push");
        idle("R8 settle");
        check("R8 hlt throttle at 5", int'(hlt_throttle), 1);
        step(0, 0, 0, 1, 0, 0, 0, "R8 pop");
        idle("R8 release");
        check("R8 hlt throttle off at 4 (low clamped to 5)", int'(hlt_throttle), 0);
        check("R10 l1 level unaffected by hlt", int'(l1_level), 2);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule